// File: doc/BRIEF.md
# Shared-Adder Arithmetic Unit

This is a purely combinational arithmetic slice. A single W-bit adder serves five operations: increment, decrement, add, subtract and compare. Each operation is chosen by its own select pin. The control logic decides three things for the adder's second operand: whether it is forced to zero, whether it is bit-inverted, and whether the carry-in is set. Those three choices are enough to turn one adder into all five operations.

The unit returns the sum and three flags: sign, carry and zero. It also returns two enables. `wr_en_o` tells the surrounding datapath whether to write the result back. `flag_en_o` tells it whether to capture the flags. Compare runs exactly like subtract, but it withholds the write enable, so only the flags are meant to be kept. The unit holds no state. Registers for flags and operands belong to the caller.

Top module: `arith_unit`

## Requirements
- R1: With only `op_inc_i` high, `result_o` equals `src_i + 1` modulo 256, and `carry_o` is 1 exactly when `src_i` is 0xFF.
- R2: With only `op_dec_i` high, `result_o` equals `src_i - 1` modulo 256, formed as `src_i + 0xFF`. `carry_o` is 1 for every `src_i` except 0x00.
- R3: With only `op_add_i` high, `result_o` equals `src_i + acc_i` modulo 256, and `carry_o` is bit 8 of the 9-bit sum.
- R4: With only `op_sub_i` high, `result_o` equals `src_i - acc_i` modulo 256, formed as `src_i + ~acc_i + 1`. `carry_o` is 1 exactly when `src_i >= acc_i` (unsigned).
- R5: With only `op_cmp_i` high, `result_o`, `sign_o`, `carry_o` and `zero_o` match what subtract gives for the same operands, and `wr_en_o` is 0.
- R6: Whenever exactly one select is high, `sign_o` equals `result_o[7]` and `zero_o` is 1 exactly when `result_o` is 0x00.
- R7: `flag_en_o` is 1 whenever exactly one select is high. `wr_en_o` is 1 only when that select is inc, dec, add or sub.
- R8: When no select is high, or more than one is high, `result_o`, `sign_o`, `carry_o`, `zero_o`, `wr_en_o` and `flag_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 8 | Source operand, the adder's first input |
| acc_i | input | 8 | Accumulator operand, used by add, sub and cmp |
| op_inc_i | input | 1 | Select increment |
| op_dec_i | input | 1 | Select decrement |
| op_add_i | input | 1 | Select add |
| op_sub_i | input | 1 | Select subtract |
| op_cmp_i | input | 1 | Select compare (subtract without write-back) |
| result_o | output | 8 | Adder sum |
| sign_o | output | 1 | Sign flag, the result MSB |
| carry_o | output | 1 | Carry out of the MSB |
| zero_o | output | 1 | Result-is-zero flag |
| wr_en_o | output | 1 | Result write-back enable |
| flag_en_o | output | 1 | Flag capture enable |

## Verification
The unit holds no state, so a wrong control decode shows at the ports in the same time step as the select that triggers it. A stuck invert or carry-in control shifts the result by one, or complements the operand, for a whole class of inputs. A wrong zero-forcing control lets `acc_i` leak into increment or decrement. A write-enable fault shows only under compare, and a fault in the select validity check shows only when the selects are idle or collide. The bench sweeps every operand pair for each operation and then drives the illegal select patterns, so each of these faults is caught at its first affected vector.

// File: rtl/arith_pkg.sv
package arith_pkg;
  localparam int unsigned OP_N   = 5;
  localparam int unsigned OP_INC = 0;
  localparam int unsigned OP_DEC = 1;
  localparam int unsigned OP_ADD = 2;
  localparam int unsigned OP_SUB = 3;
  localparam int unsigned OP_CMP = 4;

  typedef struct packed {
    logic b_zero;   // force second operand to zero
    logic b_inv;    // invert second operand
    logic cin;
    logic wr_en;
    logic flag_en;
  } arith_ctrl_t;
endpackage

// File: rtl/arith_ctrl.sv
module arith_ctrl
  import arith_pkg::*;
(
  input  logic [OP_N-1:0] sel_i,
  output arith_ctrl_t     ctrl_o
);
  logic valid;
  assign valid = $onehot(sel_i);

  always_comb begin
    ctrl_o = '0;
    if (valid) begin
      ctrl_o.flag_en = 1'b1;
      ctrl_o.b_zero  = sel_i[OP_INC] | sel_i[OP_DEC];
      ctrl_o.b_inv   = sel_i[OP_DEC] | sel_i[OP_SUB] | sel_i[OP_CMP];
      ctrl_o.cin     = sel_i[OP_INC] | sel_i[OP_SUB] | sel_i[OP_CMP];
      ctrl_o.wr_en   = ~sel_i[OP_CMP];
    end
  end
endmodule

// File: rtl/arith_opnd.sv
module arith_opnd #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic         b_zero_i,
  input  logic         b_inv_i,
  output logic [W-1:0] b_o
);
  logic [W-1:0] gated;
  assign gated = b_zero_i ? '0 : acc_i;
  assign b_o   = b_inv_i ? ~gated : gated;
endmodule

// File: rtl/arith_adder.sv
module arith_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] acc_i,
  input  logic         op_inc_i,
  input  logic         op_dec_i,
  input  logic         op_add_i,
  input  logic         op_sub_i,
  input  logic         op_cmp_i,
  output logic [W-1:0] result_o,
  output logic         sign_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         wr_en_o,
  output logic         flag_en_o
);
  logic [OP_N-1:0] sel;
  arith_ctrl_t     ctrl;
  logic [W-1:0]    b_opnd;
  logic [W-1:0]    sum;
  logic            cout;

  assign sel = {op_cmp_i, op_sub_i, op_add_i, op_dec_i, op_inc_i};

  arith_ctrl u_ctrl (
    .sel_i  (sel),
    .ctrl_o (ctrl)
  );

  arith_opnd #(.W(W)) u_opnd (
    .acc_i    (acc_i),
    .b_zero_i (ctrl.b_zero),
    .b_inv_i  (ctrl.b_inv),
    .b_o      (b_opnd)
  );

  arith_adder #(.W(W)) u_add (
    .a_i    (src_i),
    .b_i    (b_opnd),
    .cin_i  (ctrl.cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  // idle or colliding selects: drive everything low
  assign result_o  = ctrl.flag_en ? sum : '0;
  assign sign_o    = ctrl.flag_en & sum[W-1];
  assign carry_o   = ctrl.flag_en & cout;
  assign zero_o    = ctrl.flag_en & ~|sum;
  assign wr_en_o   = ctrl.wr_en;
  assign flag_en_o = ctrl.flag_en;
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] src_i,
  input logic [W-1:0] acc_i,
  input logic         op_inc_i,
  input logic         op_dec_i,
  input logic         op_add_i,
  input logic         op_sub_i,
  input logic         op_cmp_i,
  input logic [W-1:0] result_o,
  input logic         sign_o,
  input logic         carry_o,
  input logic         zero_o,
  input logic         wr_en_o,
  input logic         flag_en_o
);
  logic [4:0]   sel;
  logic         one;
  logic [W-1:0] one_w;
  assign sel   = {op_cmp_i, op_sub_i, op_add_i, op_dec_i, op_inc_i};
  assign one   = ($countones(sel) == 1);
  assign one_w = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (one && op_inc_i) AST_INC_SUM: assert (result_o == src_i + one_w); // R1
    if (one && op_dec_i) AST_DEC_CARRY: assert (carry_o == (src_i != '0)); // R2
    if (one && op_sub_i) AST_SUB_NO_BORROW: assert (carry_o == (src_i >= acc_i)); // R4
    if (one && op_cmp_i) AST_CMP_NO_WRITE: assert (!wr_en_o && zero_o == (src_i == acc_i)); // R5
    if (one) AST_SIGN_MSB: assert (sign_o == result_o[W-1]); // R6
    if (one) AST_FLAG_EN: assert (flag_en_o); // R7
    if (!one) AST_IDLE_QUIET: assert (result_o == '0 && !sign_o && !carry_o && !zero_o && !wr_en_o && !flag_en_o); // R8
  end
endmodule

bind arith_unit arith_unit_chk #(.W(W)) u_chk (.*);

// File: tb/arith_unit_tb_top.sv
`timescale 1ns/1ps
module arith_unit_tb_top;
  localparam int W = 8;

  logic clk;
  logic rst_ni;
  logic [W-1:0] src, acc, res;
  logic inc, dec, add, sub, cmp;
  logic s, c, z, wr, fe;
  int   n_cmp, n_bad;
  bit   done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  arith_unit #(.W(W)) dut_i (
    .src_i(src), .acc_i(acc),
    .op_inc_i(inc), .op_dec_i(dec), .op_add_i(add), .op_sub_i(sub), .op_cmp_i(cmp),
    .result_o(res), .sign_o(s), .carry_o(c), .zero_o(z),
    .wr_en_o(wr), .flag_en_o(fe)
  );

  // op index: 0 inc, 1 dec, 2 add, 3 sub, 4 cmp, 5 none
  task automatic run(input int op, input int sv, input int av, input string tag);
    int b, cin, tot, er, ec, es, ez, ew, ef;
    {cmp, sub, add, dec, inc} = (op < 5) ? (5'b1 << op) : 5'b0;
    src = sv[W-1:0];
    acc = av[W-1:0];
    #1;
    case (op)
      0: begin b = 0;           cin = 1; end
      1: begin b = 255;         cin = 0; end
      2: begin b = av;          cin = 0; end
      3, 4: begin b = 255 - av; cin = 1; end
      default: begin b = 0;     cin = 0; end
    endcase
    tot = sv + b + cin;
    if (op < 5) begin
      er = tot % 256; ec = tot / 256; es = er / 128; ez = (er == 0) ? 1 : 0;
      ew = (op == 4) ? 0 : 1; ef = 1;
    end else begin
      er = 0; ec = 0; es = 0; ez = 0; ew = 0; ef = 0;
    end
    n_cmp++;
    if (res !== er[W-1:0] || c !== ec[0] || s !== es[0] || z !== ez[0] ||
        wr !== ew[0] || fe !== ef[0]) begin
      n_bad++;
      $display("FAIL %s op=%0d src=%02h acc=%02h act res=%02h s%0b c%0b z%0b wr%0b fe%0b exp res=%02h s%0b c%0b z%0b wr%0b fe%0b",
               tag, op, sv, av, res, s, c, z, wr, fe, er[7:0], es[0], ec[0], ez[0], ew[0], ef[0]);
    end
  endtask

  task automatic raw(input logic [4:0] pat, input int sv, input int av);
    {cmp, sub, add, dec, inc} = pat;
    src = sv[W-1:0];
    acc = av[W-1:0];
    #1;
    n_cmp++;
    if (res !== '0 || s || c || z || wr || fe) begin
      n_bad++;
      $display("FAIL R8 sel=%05b act res=%02h s%0b c%0b z%0b wr%0b fe%0b exp all zero",
               pat, res, s, c, z, wr, fe);
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    rst_ni = 1'b0;
    {cmp, sub, add, dec, inc} = '0; src = '0; acc = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    run(5, 0, 0, "R8_reset_idle");
    for (int i = 0; i < 256; i++) run(0, i, 0, "R1_R6_R7");
    for (int i = 0; i < 256; i++) run(1, i, 0, "R2_R6_R7");
    for (int i = 0; i < 256; i++) run(1, i, 255 - i, "R2_acc_ignored");
    for (int i = 0; i < 256; i++) run(0, i, i ^ 8'h5a, "R1_acc_ignored");
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++) begin
        run(2, i, j, "R3_R6_R7");
        run(3, i, j, "R4_R6_R7");
        run(4, i, j, "R5_R6_R7");
      end
    for (int i = 0; i < 256; i += 17) run(5, i, 255 - i, "R8_none");
    for (int p = 0; p < 32; p++)
      if ($countones(p[4:0]) > 1) raw(p[4:0], p * 7, p * 3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act running exp done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule